// File: doc/BRIEF.md
# Ternary Trit-wise Logic Unit

This block applies a three-valued logic function to each trit position of one or two ternary words. Every trit is carried on two wires. The block has no clock and no state: an opcode selects the function, and the result word follows the inputs through combinational logic only. No value ever crosses from one trit position to another.

There are five two-operand functions: minimum, maximum, their inverted forms, and a product-based exclusive function. There are six one-operand functions, which read only operand A: three inverters (standard, negative and positive) and three membership tests (the trit is unknown, false or true). The unit sits beside the arithmetic datapath of a ternary core. Shifts, rotates, flags and register access are handled outside it.

Top module: `tlu_top`

## Requirements
- R1: Trit coding on both input and output: `00` means -1, `01` means 0 and `10` means +1. An input trit coded `11` is read as 0. No output trit is ever coded `11`.
- R2: Opcode 0 (minimum) gives, at each position, the smaller of the A and B trits.
- R3: Opcode 1 (maximum) gives, at each position, the larger of the A and B trits.
- R4: Opcode 2 gives the negated minimum of A and B, and opcode 3 gives the negated maximum of A and B, at each position.
- R5: Opcode 4 (exclusive function) gives -(a·b) at each position.
- R6: Opcode 5 (standard inverter) gives -a at each position.
- R7: Opcode 6 (negative inverter) gives -1 where a is +1, and +1 everywhere else.
- R8: Opcode 7 (positive inverter) gives -1 where a is -1, and +1 everywhere else.
- R9: Opcodes 8, 9 and 10 test each trit of A for 0, -1 and +1 in that order. Each gives +1 where the test holds and -1 where it does not.
- R10: Opcodes 11 to 15 give the all-zero word, with every trit coded `01`.
- R11: Each result trit depends only on the operand trits at the same position, and all positions are computed the same way.
- R12: For opcodes 5 to 10, operand B has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Function select |
| a_word | input | 40 | Operand A, 20 trits of 2 bits each, trit 0 in bits 1:0 |
| b_word | input | 40 | Operand B, same layout as A |
| y_word | output | 40 | Result, same layout |

## Verification
The bench applies every opcode, including the five unused ones, with an operand pattern that places all sixteen code pairs, `11` included, at different trit positions. This exposes a design that mishandles the unused code or computes one position differently from another. Random words are also applied with every opcode, and each output trit is compared against a behavioural integer model. The one-operand functions are given the same A with two different B values, which catches a design that reads B for them. Every output is checked for the forbidden `11` code, which a faulty encoder would produce for the all-negative case or for an unused opcode.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int TRIT_W = 2;
  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t T_NEG  = 2'b00;
  localparam trit_t T_ZERO = 2'b01;
  localparam trit_t T_POS  = 2'b10;

  localparam int FN_MIN   = 0;
  localparam int FN_MAX   = 1;
  localparam int FN_AMIN  = 2;
  localparam int FN_AMAX  = 3;
  localparam int FN_XOR   = 4;
  localparam int FN_STI   = 5;
  localparam int FN_NTI   = 6;
  localparam int FN_PTI   = 7;
  localparam int FN_ISUNK = 8;
  localparam int FN_ISF   = 9;
  localparam int FN_IST   = 10;
  localparam int NUM_FN   = 11;

  function automatic int t_val(trit_t c);
    case (c)
      T_NEG:   return -1;
      T_POS:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic trit_t t_code(int v);
    if (v > 0)      return T_POS;
    else if (v < 0) return T_NEG;
    else            return T_ZERO;
  endfunction

  function automatic int t_min(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int t_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int t_sti(int a);
    return -a;
  endfunction

  function automatic int t_nti(int a);
    return (a == 1) ? -1 : 1;
  endfunction

  function automatic int t_pti(int a);
    return (a == -1) ? -1 : 1;
  endfunction

  function automatic int t_xor(int a, int b);
    return -(a * b);
  endfunction

  function automatic int t_test(bit hit);
    return hit ? 1 : -1;
  endfunction
endpackage

// File: rtl/tlu_op_decode.sv
module tlu_op_decode
  import tlu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0]   op_sel,
  output logic [NUM_FN-1:0] fn_hot
);
  always_comb begin
    fn_hot = '0;
    for (int k = 0; k < NUM_FN; k++) begin
      if (int'(op_sel) == k) fn_hot[k] = 1'b1;
    end
  end

  // R10
  always_comb begin
    if (!$isunknown(op_sel)) begin
      fn_sel_onehot_chk: assert ($onehot0(fn_hot));
    end
  end

  // R10
  always_comb begin
    if (!$isunknown(op_sel) && int'(op_sel) >= NUM_FN) begin
      unused_op_idle_chk: assert (fn_hot == '0);
    end
  end
endmodule

// File: rtl/tlu_trit_cell.sv
module tlu_trit_cell
  import tlu_pkg::*;
(
  input  logic [NUM_FN-1:0] fn_hot,
  input  trit_t             a_t,
  input  trit_t             b_t,
  output trit_t             y_t
);
  int va, vb;
  int mn_v, mx_v;
  trit_t y_min, y_max, y_amin, y_amax, y_xor;
  trit_t y_sti, y_nti, y_pti, y_unk, y_f, y_t_hit;

  always_comb begin
    va   = t_val(a_t);
    vb   = t_val(b_t);
    mn_v = t_min(va, vb);
    mx_v = t_max(va, vb);
    y_min   = t_code(mn_v);
    y_max   = t_code(mx_v);
    y_amin  = t_code(t_sti(mn_v));
    y_amax  = t_code(t_sti(mx_v));
    y_xor   = t_code(t_xor(va, vb));
    y_sti   = t_code(t_sti(va));
    y_nti   = t_code(t_nti(va));
    y_pti   = t_code(t_pti(va));
    y_unk   = t_code(t_test(va == 0));
    y_f     = t_code(t_test(va == -1));
    y_t_hit = t_code(t_test(va == 1));
  end

  always_comb begin
    y_t = T_ZERO;
    if (fn_hot[FN_MIN])   y_t = y_min;
    if (fn_hot[FN_MAX])   y_t = y_max;
    if (fn_hot[FN_AMIN])  y_t = y_amin;
    if (fn_hot[FN_AMAX])  y_t = y_amax;
    if (fn_hot[FN_XOR])   y_t = y_xor;
    if (fn_hot[FN_STI])   y_t = y_sti;
    if (fn_hot[FN_NTI])   y_t = y_nti;
    if (fn_hot[FN_PTI])   y_t = y_pti;
    if (fn_hot[FN_ISUNK]) y_t = y_unk;
    if (fn_hot[FN_ISF])   y_t = y_f;
    if (fn_hot[FN_IST])   y_t = y_t_hit;
  end

  // R1
  always_comb begin
    if (!$isunknown({fn_hot, a_t, b_t})) begin
      no_bad_code_chk: assert (y_t != 2'b11);
    end
  end

  // R2
  always_comb begin
    if (!$isunknown({fn_hot, a_t, b_t}) && fn_hot[FN_MIN]) begin
      min_bound_chk: assert (t_val(y_t) <= va && t_val(y_t) <= vb);
    end
  end

  // R3
  always_comb begin
    if (!$isunknown({fn_hot, a_t, b_t}) && fn_hot[FN_MAX]) begin
      max_bound_chk: assert (t_val(y_t) >= va && t_val(y_t) >= vb);
    end
  end

  // R5
  always_comb begin
    if (!$isunknown({fn_hot, a_t, b_t}) && fn_hot[FN_XOR] && (va == 0 || vb == 0)) begin
      xor_zero_chk: assert (y_t == T_ZERO);
    end
  end

  // R9
  always_comb begin
    if (!$isunknown({fn_hot, a_t}) && (fn_hot[FN_ISUNK] || fn_hot[FN_ISF] || fn_hot[FN_IST])) begin
      test_binary_chk: assert (y_t == T_POS || y_t == T_NEG);
    end
  end
endmodule

// File: rtl/tlu_top.sv
module tlu_top
  import tlu_pkg::*;
#(
  parameter int TRITS = 20,
  parameter int OP_W  = 4,
  localparam int WORD_W = TRITS * TRIT_W
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  output logic [WORD_W-1:0] y_word
);
  logic [NUM_FN-1:0] fn_hot;

  tlu_op_decode #(.OP_W(OP_W)) u_dec (
    .op_sel (op_sel),
    .fn_hot (fn_hot)
  );

  // R11: one identical cell per position, no cross-position paths
  for (genvar p = 0; p < TRITS; p++) begin : g_cell
    tlu_trit_cell u_cell (
      .fn_hot (fn_hot),
      .a_t    (a_word[p*TRIT_W +: TRIT_W]),
      .b_t    (b_word[p*TRIT_W +: TRIT_W]),
      .y_t    (y_word[p*TRIT_W +: TRIT_W])
    );
  end
endmodule

// File: tb/tlu_top_test.sv
module tlu_top_test;
  localparam int TRITS = 20;
  localparam int WW = TRITS * 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]    op_sel;
  logic [WW-1:0] a_word, b_word;
  logic [WW-1:0] y_word;

  int n_vec = 0;
  int n_bad = 0;

  tlu_top uut (
    .op_sel (op_sel),
    .a_word (a_word),
    .b_word (b_word),
    .y_word (y_word)
  );

  function automatic int dec(logic [1:0] c);
    if (c == 2'b00) return -1;
    if (c == 2'b10) return 1;
    return 0;
  endfunction

  function automatic string tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      8, 9, 10: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int model(int op, int a, int b);
    int lo, hi;
    lo = a; if (b < lo) lo = b;
    hi = a; if (b > hi) hi = b;
    case (op)
      0: return lo;
      1: return hi;
      2: return 0 - lo;
      3: return 0 - hi;
      4: return 0 - a * b;
      5: return 0 - a;
      6: return (a == 1) ? -1 : 1;
      7: return (a == -1) ? -1 : 1;
      8: return (a == 0) ? 1 : -1;
      9: return (a == -1) ? 1 : -1;
      10: return (a == 1) ? 1 : -1;
      default: return 0;
    endcase
  endfunction

  task automatic apply(int op, logic [WW-1:0] a, logic [WW-1:0] b);
    logic [WW-1:0] exp_w;
    @(posedge clk);
    #1;
    op_sel = op[3:0];
    a_word = a;
    b_word = b;
    for (int p = 0; p < TRITS; p++) begin
      int e = model(op, dec(a[2*p +: 2]), dec(b[2*p +: 2]));
      exp_w[2*p +: 2] = 2'(e + 1);
    end
    @(negedge clk);
    n_vec++;
    if (y_word !== exp_w) begin
      n_bad++;
      $display("FAIL %s/R11 op=%0d a=%h b=%h actual=%h expected=%h",
               tag(op), op, a, b, y_word, exp_w);
    end
    for (int p = 0; p < TRITS; p++) begin
      if (y_word[2*p +: 2] === 2'b11) begin
        n_bad++;
        $display("FAIL R1 op=%0d trit=%0d actual=11 expected=not 11", op, p);
      end
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [WW-1:0] pa, pb, ra, rb, y1;
    op_sel = '0;
    a_word = '0;
    b_word = '0;
    // R1 and R11: positions 0..15 carry all 16 code pairs, 11 included
    for (int p = 0; p < TRITS; p++) begin
      pa[2*p +: 2] = 2'(p % 4);
      pb[2*p +: 2] = 2'((p / 4) % 4);
    end
    for (int op = 0; op < 16; op++) begin
      apply(op, {TRITS{2'b01}}, {TRITS{2'b01}});
      apply(op, pa, pb);
      apply(op, pb, pa);
      apply(op, {TRITS{2'b00}}, {TRITS{2'b10}});
      for (int k = 0; k < 40; k++) begin
        for (int p = 0; p < TRITS; p++) begin
          ra[2*p +: 2] = 2'($urandom_range(0, 2));
          rb[2*p +: 2] = 2'($urandom_range(0, 3));
        end
        apply(op, ra, rb);
      end
    end
    // R12: B must not influence one-operand functions
    for (int op = 5; op <= 10; op++) begin
      for (int k = 0; k < 10; k++) begin
        ra = {$urandom, $urandom};
        apply(op, ra, {$urandom, $urandom});
        y1 = y_word;
        apply(op, ra, ~rb);
        rb = {$urandom, $urandom};
        if (y_word !== y1) begin
          n_bad++;
          $display("FAIL R12 op=%0d actual=%h expected=%h", op, y_word, y1);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule